// File: doc/BRIEF.md
# Complementary Dead-Time Generator

This block turns one PWM command into two gate commands that never conduct at the same time. One is a main power drive and the other is an auxiliary drive. On a rising PWM edge the auxiliary switch is released at once, and the power switch is turned on only after a programmable gap. On a falling PWM edge the power switch is released at once, and the auxiliary switch is engaged only after a second, independent gap. Either gap can be cut short by a zero-voltage sense strobe, so the waiting switch turns on as soon as its voltage has collapsed.

The gaps are given as clock-cycle counts. At a 125 MHz clock, values from about 6 to 63 cover a 50 ns to 500 ns range. A delay must be shorter than the PWM phase it belongs to, or that phase is truncated. An enable input puts the block to sleep. In sleep the power command is held low and the auxiliary pin driver is turned off. A static mode bit selects how the auxiliary level is encoded: active-high for a truly complementary N-channel pair, or active-low for a P-channel auxiliary switch.

Top module: `cdt_gen`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `pwr_drv`, `aux_oe` and `aux_lvl` are all 0.
- R2: `pwm_in`, `en_in`, `zvs_pwr_in` and `zvs_aux_in` each pass through two flops. A `pwm_in` change first captured at clock edge k shows at the outputs after edge k+2.
- R3: On a rising PWM edge the auxiliary switch becomes inactive in the same cycle as the edge takes effect. `pwr_drv` rises exactly `t_pwr_dly` cycles later, and both switches are off in between.
- R4: On a falling PWM edge `pwr_drv` falls in the same cycle as the edge takes effect. The auxiliary switch becomes active exactly `t_aux_dly` cycles later.
- R5: A delay value of 0 gives no gap. The released switch and the engaged switch change in the same cycle.
- R6: If the synchronized `zvs_pwr_in` (or `zvs_aux_in`) is high while the power (or auxiliary) gap is running, that gap ends and the switch turns on at the next edge. A strobe first captured at edge k turns the switch on after edge k+2.
- R7: A falling PWM edge during the power gap cancels the pending power turn-on. `pwr_drv` stays 0, and the auxiliary gap starts.
- R8: A rising PWM edge during the auxiliary gap cancels the pending auxiliary turn-on. The auxiliary switch stays inactive, and the power gap starts.
- R9: While the synchronized enable is low, `pwr_drv`=0, `aux_oe`=0 and `aux_lvl`=0 from the next edge on, and any running gap is abandoned.
- R10: When the synchronized enable returns high, the outputs take the state that matches the synchronized PWM level at the next edge, with no gap. PWM high gives power on and auxiliary inactive; PWM low gives auxiliary active and power off.
- R11: The auxiliary active state is encoded by `aux_compl`. With `aux_compl`=1, `aux_lvl`=1 means active. With `aux_compl`=0, `aux_lvl`=0 means active. In both cases `aux_oe`=1 whenever the block is awake.
- R12: `pwr_drv`=1 and an active auxiliary switch never occur in the same cycle.
- R13: Each gap length is captured at its PWM edge. Changing `t_pwr_dly` or `t_aux_dly` while a gap runs does not alter that gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_in | input | 1 | Asynchronous PWM command |
| en_in | input | 1 | Asynchronous enable; low selects sleep |
| zvs_pwr_in | input | 1 | Zero-voltage strobe that ends the power gap |
| zvs_aux_in | input | 1 | Zero-voltage strobe that ends the auxiliary gap |
| aux_compl | input | 1 | Static mode bit: 1 = active-high auxiliary, 0 = active-low |
| t_pwr_dly | input | DLY_W | Gap before power turn-on, in cycles |
| t_aux_dly | input | DLY_W | Gap before auxiliary turn-on, in cycles |
| pwr_drv | output | 1 | Power switch command |
| aux_lvl | output | 1 | Auxiliary switch level |
| aux_oe | output | 1 | Auxiliary pin drive enable (0 = high impedance) |

## Verification
A per-cycle reference model runs alongside directed sequences. The directed sequences separate a rising edge from a falling edge, and a gap of zero from a nonzero gap. They also separate a gap that runs to its end from one ended by a sense strobe, and one cancelled by the opposite edge. Sleep entry is tried from the power-on state, and wake-up is tried with PWM both high and low, to show that the outputs follow the level without a gap. The random phase lengths often fall below the programmed delays, which exercises truncated phases. Delay values change in mid-gap to show that the captured length holds. Both auxiliary encodings are used, and the overlap check is run every cycle.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

    localparam int unsigned SYNC_DEPTH = 2;
    localparam int unsigned N_GAPS     = 2;
    localparam int unsigned GAP_UP     = 0;  // power turn-on gap
    localparam int unsigned GAP_DN     = 1;  // auxiliary turn-on gap

    typedef enum logic [2:0] {
        PH_SLEEP  = 3'd0,
        PH_AUX    = 3'd1,
        PH_GAP_UP = 3'd2,
        PH_PWR    = 3'd3,
        PH_GAP_DN = 3'd4
    } phase_e;

    typedef struct packed {
        logic pwr;
        logic aux_act;
        logic aux_oe;
    } drive_t;

    function automatic drive_t phase_drive(phase_e ph);
        drive_t d;
        d.pwr     = (ph == PH_PWR);
        d.aux_act = (ph == PH_AUX);
        d.aux_oe  = (ph != PH_SLEEP);
        return d;
    endfunction

    function automatic logic aux_pin(drive_t d, logic compl_mode);
        return d.aux_oe & (compl_mode ? d.aux_act : ~d.aux_act);
    endfunction

endpackage

// File: rtl/cdt_sync.sv
module cdt_sync #(
    parameter int unsigned WIDTH  = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cdt_dt_timer.sv
module cdt_dt_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] len,
    input  logic         kill,
    input  logic         sense,
    output logic         busy,
    output logic         expire
);
    logic [W-1:0] cnt;

    assign busy   = (cnt != '0);
    assign expire = busy && ((cnt == W'(1)) || sense);

    always_ff @(posedge clk) begin
        if (rst || kill)  cnt <= '0;
        else if (load)    cnt <= len;
        else if (expire)  cnt <= '0;
        else if (busy)    cnt <= cnt - W'(1);
    end

    // R13: a running gap only counts down, whatever the delay input does
    a_r13_count_down: assert property (@(posedge clk) disable iff (rst)
        (busy && !load && !kill) |=> (cnt < $past(cnt)));

    // R6: a sense strobe during a running gap ends it
    a_r6_sense_ends_gap: assert property (@(posedge clk) disable iff (rst)
        (busy && sense && !load && !kill) |=> !busy);
endmodule

// File: rtl/cdt_phase_seq.sv
module cdt_phase_seq
    import cdt_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         pwm_s,
    input  logic         en_s,
    input  logic         zvs_up_s,
    input  logic         zvs_dn_s,
    input  logic [W-1:0] t_up,
    input  logic [W-1:0] t_dn,
    output drive_t       drv
);
    phase_e phase, nxt;
    logic   pwm_d;
    logic   rise, fall;

    logic [N_GAPS-1:0]        load, kill, sense, busy, expire;
    logic [N_GAPS-1:0][W-1:0] len;

    assign rise = pwm_s & ~pwm_d;
    assign fall = ~pwm_s & pwm_d;

    assign len[GAP_UP]   = t_up;
    assign len[GAP_DN]   = t_dn;
    assign sense[GAP_UP] = zvs_up_s;
    assign sense[GAP_DN] = zvs_dn_s;

    for (genvar g = 0; g < N_GAPS; g++) begin : g_gap
        cdt_dt_timer #(.W(W)) tmr_i (
            .clk    (clk),
            .rst    (rst),
            .load   (load[g]),
            .len    (len[g]),
            .kill   (kill[g]),
            .sense  (sense[g]),
            .busy   (busy[g]),
            .expire (expire[g])
        );
    end

    always_comb begin
        nxt  = phase;
        load = '0;
        kill = '0;
        if (!en_s) begin
            nxt  = PH_SLEEP;
            kill = '1;
        end else if (phase == PH_SLEEP) begin
            nxt = pwm_s ? PH_PWR : PH_AUX;
        end else if (rise) begin
            kill[GAP_DN] = 1'b1;
            load[GAP_UP] = (t_up != '0);
            nxt          = (t_up == '0) ? PH_PWR : PH_GAP_UP;
        end else if (fall) begin
            kill[GAP_UP] = 1'b1;
            load[GAP_DN] = (t_dn != '0);
            nxt          = (t_dn == '0) ? PH_AUX : PH_GAP_DN;
        end else if (phase == PH_GAP_UP && expire[GAP_UP]) begin
            nxt = PH_PWR;
        end else if (phase == PH_GAP_DN && expire[GAP_DN]) begin
            nxt = PH_AUX;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_SLEEP;
            pwm_d <= 1'b0;
        end else begin
            phase <= nxt;
            pwm_d <= pwm_s;
        end
    end

    assign drv = phase_drive(phase);

    a_r3_rise_drops_aux: assert property (@(posedge clk) disable iff (rst)
        (en_s && phase != PH_SLEEP && rise) |=> !drv.aux_act);

    a_r4_fall_drops_pwr: assert property (@(posedge clk) disable iff (rst)
        (en_s && phase != PH_SLEEP && fall) |=> !drv.pwr);

    a_r9_sleep_safe: assert property (@(posedge clk) disable iff (rst)
        !en_s |=> (!drv.pwr && !drv.aux_oe));

    a_r10_wake_level: assert property (@(posedge clk) disable iff (rst)
        (en_s && phase == PH_SLEEP) |=>
            (drv.pwr == $past(pwm_s)) && (drv.aux_act == !$past(pwm_s)));
endmodule

// File: rtl/cdt_gen.sv
module cdt_gen
    import cdt_pkg::*;
#(
    parameter int unsigned DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwm_in,
    input  logic             en_in,
    input  logic             zvs_pwr_in,
    input  logic             zvs_aux_in,
    input  logic             aux_compl,
    input  logic [DLY_W-1:0] t_pwr_dly,
    input  logic [DLY_W-1:0] t_aux_dly,
    output logic             pwr_drv,
    output logic             aux_lvl,
    output logic             aux_oe
);
    localparam int unsigned N_ASYNC = 4;

    logic [N_ASYNC-1:0] raw_in, syn;
    drive_t             drv;

    assign raw_in = {en_in, pwm_in, zvs_pwr_in, zvs_aux_in};

    cdt_sync #(.WIDTH(N_ASYNC), .STAGES(SYNC_DEPTH)) sync_i (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (syn)
    );

    cdt_phase_seq #(.W(DLY_W)) seq_i (
        .clk      (clk),
        .rst      (rst),
        .pwm_s    (syn[2]),
        .en_s     (syn[3]),
        .zvs_up_s (syn[1]),
        .zvs_dn_s (syn[0]),
        .t_up     (t_pwr_dly),
        .t_dn     (t_aux_dly),
        .drv      (drv)
    );

    assign pwr_drv = drv.pwr;
    assign aux_oe  = drv.aux_oe;
    assign aux_lvl = aux_pin(drv, aux_compl);

    // R12: power and active auxiliary never overlap at the pins
    a_r12_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(pwr_drv && aux_oe && (aux_lvl == aux_compl)));
endmodule

// File: tb/cdt_gen_tb_top.sv
module cdt_gen_tb_top;
    localparam int W = 8;
    localparam int M_SLEEP = 0, M_AUX = 1, M_UPW = 2, M_PWR = 3, M_DNW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwm = 1'b0, en = 1'b1, zp = 1'b0, za = 1'b0, compl = 1'b1;
    logic [W-1:0] t1 = '0, t2 = '0;
    logic pwr_drv, aux_lvl, aux_oe;

    int  n_chk = 0, n_fail = 0;
    bit  cmp_on = 1'b0, fin = 1'b0;

    always #4 clk = ~clk;

    cdt_gen #(.DLY_W(W)) dut_i (
        .clk(clk), .rst(rst), .pwm_in(pwm), .en_in(en),
        .zvs_pwr_in(zp), .zvs_aux_in(za), .aux_compl(compl),
        .t_pwr_dly(t1), .t_aux_dly(t2),
        .pwr_drv(pwr_drv), .aux_lvl(aux_lvl), .aux_oe(aux_oe)
    );

    // reference model: {en,pwm,zp,za} through two stages, then the phase rules
    logic [3:0] m_s1 = '0, m_s2 = '0;
    logic       m_prev = 1'b0;
    int         m_st = M_SLEEP;
    int         m_rem = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_s1 <= '0; m_s2 <= '0; m_prev <= 1'b0; m_st <= M_SLEEP; m_rem <= 0;
        end else begin
            m_s1   <= {en, pwm, zp, za};
            m_s2   <= m_s1;
            m_prev <= m_s2[2];
            if (!m_s2[3]) begin
                m_st <= M_SLEEP; m_rem <= 0;
            end else if (m_st == M_SLEEP) begin
                m_st <= m_s2[2] ? M_PWR : M_AUX;
            end else if (m_s2[2] && !m_prev) begin
                m_st <= (t1 == 0) ? M_PWR : M_UPW; m_rem <= int'(t1);
            end else if (!m_s2[2] && m_prev) begin
                m_st <= (t2 == 0) ? M_AUX : M_DNW; m_rem <= int'(t2);
            end else if (m_st == M_UPW) begin
                if (m_rem == 1 || m_s2[1]) m_st <= M_PWR; else m_rem <= m_rem - 1;
            end else if (m_st == M_DNW) begin
                if (m_rem == 1 || m_s2[0]) m_st <= M_AUX; else m_rem <= m_rem - 1;
            end
        end
    end

    function automatic logic exp_lvl(int st, logic c);
        if (st == M_SLEEP) return 1'b0;
        return c ? (st == M_AUX) : (st != M_AUX);
    endfunction

    function automatic logic aux_active();
        return aux_oe && (aux_lvl == compl);
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on) begin
            chk(pwr_drv === (m_st == M_PWR), "R3/R4 model pwr_drv", pwr_drv, m_st == M_PWR);
            chk(aux_oe === (m_st != M_SLEEP), "R9 model aux_oe", aux_oe, m_st != M_SLEEP);
            chk(aux_lvl === exp_lvl(m_st, compl), "R11 model aux_lvl", aux_lvl, exp_lvl(m_st, compl));
            chk(!(pwr_drv && aux_active()), "R12 overlap", pwr_drv && aux_active(), 0);
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic settle_low();
        pwm = 1'b0; step(40);
    endtask

    task automatic settle_high();
        pwm = 1'b1; step(40);
    endtask

    initial begin
        #(8 * 150000);
        if (!fin) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        step(2);
        chk(!pwr_drv && !aux_oe && !aux_lvl, "R1 reset outputs", {pwr_drv, aux_oe, aux_lvl}, 0);
        rst = 1'b0;
        cmp_on = 1'b1;
        step(1);
        chk(!pwr_drv && !aux_oe, "R1 first cycle after reset", {pwr_drv, aux_oe}, 0);
        t1 = 8'd3; t2 = 8'd4;
        settle_low();

        // R2 latency and R3 power gap
        pwm = 1'b1;
        step(2); chk(aux_active(), "R2 aux still active two edges in", aux_active(), 1);
        step(1); chk(!aux_active() && !pwr_drv, "R2 aux released after edge k+2", aux_active(), 0);
        step(2); chk(!pwr_drv, "R3 power held in gap", pwr_drv, 0);
        step(1); chk(pwr_drv, "R3 power on after t1 cycles", pwr_drv, 1);
        step(30);

        // R4 auxiliary gap
        pwm = 1'b0;
        step(3); chk(!pwr_drv, "R4 power off at once", pwr_drv, 0);
        step(3); chk(!aux_active(), "R4 aux held in gap", aux_active(), 0);
        step(1); chk(aux_active(), "R4 aux on after t2 cycles", aux_active(), 1);
        step(30);

        // R5 zero gap
        t1 = 8'd0;
        pwm = 1'b1;
        step(3); chk(pwr_drv && !aux_active(), "R5 zero gap switches together", pwr_drv, 1);
        settle_low();

        // R6 sense strobe ends the power gap
        t1 = 8'd20;
        pwm = 1'b1;
        step(5); zp = 1'b1;
        step(2); chk(!pwr_drv, "R6 power off before strobe lands", pwr_drv, 0);
        step(1); chk(pwr_drv, "R6 strobe ends power gap", pwr_drv, 1);
        zp = 1'b0;
        settle_high();

        // R6 sense strobe ends the auxiliary gap
        t2 = 8'd20;
        pwm = 1'b0;
        step(5); za = 1'b1;
        step(2); chk(!aux_active(), "R6 aux off before strobe lands", aux_active(), 0);
        step(1); chk(aux_active(), "R6 strobe ends aux gap", aux_active(), 1);
        za = 1'b0;
        t2 = 8'd4;
        settle_low();

        // R7 fall during power gap
        t1 = 8'd10;
        pwm = 1'b1;
        step(5); pwm = 1'b0;
        step(6); chk(!aux_active(), "R7 aux gap running", aux_active(), 0);
        step(1); chk(aux_active(), "R7 aux on after cancel", aux_active(), 1);
        step(2); chk(!pwr_drv, "R7 power turn-on cancelled", pwr_drv, 0);
        settle_high();

        // R8 rise during auxiliary gap
        t2 = 8'd10; t1 = 8'd2;
        pwm = 1'b0;
        step(5); pwm = 1'b1;
        step(4); chk(!pwr_drv, "R8 power gap after cancel", pwr_drv, 0);
        step(1); chk(pwr_drv, "R8 power on after t1", pwr_drv, 1);
        step(3); chk(!aux_active(), "R8 aux turn-on cancelled", aux_active(), 0);
        step(20);

        // R9 sleep from power-on
        en = 1'b0;
        step(2); chk(pwr_drv, "R9 awake two edges in", pwr_drv, 1);
        step(1); chk(!pwr_drv && !aux_oe && !aux_lvl, "R9 sleep outputs", {pwr_drv, aux_oe, aux_lvl}, 0);

        // R10 wake with PWM low and high
        pwm = 1'b0; step(5);
        en = 1'b1;
        step(2); chk(!aux_oe, "R10 still asleep", aux_oe, 0);
        step(1); chk(aux_active() && !pwr_drv, "R10 wake low: aux active", aux_active(), 1);
        en = 1'b0; step(5); pwm = 1'b1; step(5);
        en = 1'b1;
        step(3); chk(pwr_drv && !aux_active(), "R10 wake high: power on without gap", pwr_drv, 1);

        // R11 encodings
        settle_low();
        compl = 1'b0; step(1);
        chk(aux_oe && !aux_lvl, "R11 inverted active level", aux_lvl, 0);
        compl = 1'b1; step(1);
        chk(aux_oe && aux_lvl, "R11 complementary active level", aux_lvl, 1);

        // R13 delay captured at the edge
        t1 = 8'd6;
        pwm = 1'b1;
        step(4); t1 = 8'd1;
        step(4); chk(!pwr_drv, "R13 gap keeps captured length", pwr_drv, 0);
        step(1); chk(pwr_drv, "R13 power on at captured length", pwr_drv, 1);

        // random phases
        for (int i = 0; i < 1500; i++) begin
            pwm = ~pwm;
            if ($urandom_range(0, 7) == 0) t1 = 8'($urandom_range(0, 15));
            if ($urandom_range(0, 7) == 0) t2 = 8'($urandom_range(0, 15));
            if ($urandom_range(0, 49) == 0) compl = ~compl;
            if ($urandom_range(0, 39) == 0) en = 1'b0;
            for (int c = 0; c < int'($urandom_range(1, 40)); c++) begin
                zp = ($urandom_range(0, 15) == 0);
                za = ($urandom_range(0, 15) == 0);
                if ($urandom_range(0, 9) == 0) t1 = 8'($urandom_range(0, 15));
                step(1);
            end
            en = 1'b1;
        end
        zp = 1'b0; za = 1'b0;
        step(10);

        fin = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule